// File: doc/BRIEF.md
# MMU Fault Status Recorder

This block captures bus-error and unassigned-access events reported by the memory system and holds them in two architectural registers: a 32-bit fault status word and a fault address word. A new event only replaces the held status when the held fault class is empty or of lower importance than a translation or protection fault. The fault class that the block records itself is the bus-error class. The block flags an overflow when an event arrives while an event of the same class is still held. From the control-register enable and no-fault bits it also decides whether the processor must take an instruction-access or a data-access trap, or whether the translation buffer must instead be flushed.

Software can clear the status in two ways. It can read it through a clearing alias, which returns the current value and zeroes the register on the next clock. It can also write through the same alias, which stores the written word filtered by a mask parameter. Fault events always take precedence over software accesses in the same cycle.

Top module: `mmu_fault_recorder`

## Requirements
- R1: After reset `stat_q` and `addr_q` are zero, and `trap_req` and `flush_req` are low.
- R2: The fault class lives in `stat_q[4:2]`. When `flt_valid` is seen at a rising edge while the held class is 0, 6 or 7, the status is rebuilt from zero after that edge. The rebuilt status has bit 16 equal to `flt_alt`, bit 5 equal to `flt_super`, bit 6 equal to `flt_exec` and bit 7 equal to `flt_write`. It holds class 5 in bits 4:2 and has bit 1 set.
- R3: When `flt_valid` arrives while the held class is 1, 2, 3 or 4, every status bit other than bit 0 keeps its value.
- R4: Bit 0 (overflow) is set after an event whenever the class after the update equals the class before it. This covers a class-5 event arriving on a held class 5, and any event arriving on a held class 1 to 4.
- R5: `addr_q` takes `flt_addr` only when the status is rebuilt and `flt_exec` is 0. Otherwise it is unchanged.
- R6: In the cycle after an event taken with `ctl_enable`=1 and `ctl_nofault`=0, `trap_req` is high for one cycle. `trap_kind` is 1 (instruction access) when the event was a fetch and 0 (data access) otherwise. In all other cases no trap is requested.
- R7: In the cycle after an event taken with `ctl_nofault`=1, `flush_req` is high for one cycle.
- R8: `sw_wr` without an event stores `sw_wdata & STAT_WMASK` into the status. The default mask is 0x0003FFFF.
- R9: `sw_clr` without an event or write leaves the status visible in that cycle and zeroes it after the next edge.
- R10: An event in the same cycle as `sw_wr` or `sw_clr` updates the status as if no software access occurred. `sw_wr` takes precedence over `sw_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault event strobe |
| flt_write | input | 1 | Event came from a store |
| flt_exec | input | 1 | Event came from an instruction fetch |
| flt_alt | input | 1 | Event used an alternate address space |
| flt_super | input | 1 | Event occurred in supervisor mode |
| flt_addr | input | AW | Faulting physical address |
| ctl_enable | input | 1 | MMU enable control bit |
| ctl_nofault | input | 1 | No-fault control bit |
| sw_clr | input | 1 | Software read of the status through the clearing alias |
| sw_wr | input | 1 | Software write through the clearing alias |
| sw_wdata | input | 32 | Software write data |
| stat_q | output | 32 | Fault status register |
| addr_q | output | AW | Fault address register |
| trap_req | output | 1 | One-cycle trap request |
| trap_kind | output | 1 | 1 = instruction access trap, 0 = data access trap |
| flush_req | output | 1 | One-cycle full translation-buffer flush request |

## Verification
The block records only class 5 by itself, so the held classes 1 to 4 that must be preserved cannot be reached from fault events alone. The bench reaches them by writing a chosen class through the masked software write path and then firing an event. The same path writes classes 6 and 7, which shows that higher classes are replaced without flagging overflow. Collisions between an event and a software write or clear are driven in one cycle to check the precedence.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
    localparam int STAT_W    = 32;
    localparam int TYPE_LSB  = 2;
    localparam int TYPE_W    = 3;
    localparam int BIT_OVF   = 0;
    localparam int BIT_VALID = 1;
    localparam int BIT_SUPER = 5;
    localparam int BIT_EXEC  = 6;
    localparam int BIT_WRITE = 7;
    localparam int BIT_ALT   = 16;
    localparam logic [TYPE_W-1:0] TYPE_BUS     = 3'd5;
    localparam logic [TYPE_W-1:0] TYPE_KEEP_HI = 3'd4;

    typedef enum logic {
        TRAP_DATA = 1'b0,
        TRAP_CODE = 1'b1
    } trap_kind_e;
endpackage

// File: rtl/mfr_status_next.sv
module mfr_status_next
    import mfr_pkg::*;
#(
    parameter int AW = 36
) (
    input  logic [STAT_W-1:0] held_stat,
    input  logic [AW-1:0]     held_addr,
    input  logic              ev_write,
    input  logic              ev_exec,
    input  logic              ev_alt,
    input  logic              ev_super,
    input  logic [AW-1:0]     ev_addr,
    output logic [STAT_W-1:0] new_stat,
    output logic [AW-1:0]     new_addr
);
    logic [TYPE_W-1:0] old_type;
    logic              replace;

    assign old_type = held_stat[TYPE_LSB +: TYPE_W];
    assign replace  = (old_type == '0) || (old_type > TYPE_KEEP_HI);

    always_comb begin
        new_stat = held_stat;
        new_addr = held_addr;
        if (replace) begin
            new_stat                      = '0;
            new_stat[BIT_ALT]             = ev_alt;
            new_stat[BIT_SUPER]           = ev_super;
            new_stat[BIT_EXEC]            = ev_exec;
            new_stat[BIT_WRITE]           = ev_write;
            new_stat[TYPE_LSB +: TYPE_W]  = TYPE_BUS;
            new_stat[BIT_VALID]           = 1'b1;
            if (!ev_exec) begin
                new_addr = ev_addr;
            end
        end
        if (new_stat[TYPE_LSB +: TYPE_W] == old_type) begin
            new_stat[BIT_OVF] = 1'b1;
        end
    end
endmodule

// File: rtl/mfr_trap_ctl.sv
module mfr_trap_ctl
    import mfr_pkg::*;
(
    input  logic       fire,
    input  logic       ev_exec,
    input  logic       en,
    input  logic       nofault,
    output logic       trap,
    output trap_kind_e kind,
    output logic       flush
);
    always_comb begin
        trap  = fire && en && !nofault;
        kind  = ev_exec ? TRAP_CODE : TRAP_DATA;
        flush = fire && nofault;
    end
endmodule

// File: rtl/mmu_fault_recorder.sv
module mmu_fault_recorder
    import mfr_pkg::*;
#(
    parameter int                AW         = 36,
    parameter logic [STAT_W-1:0] STAT_WMASK = 32'h0003_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic              flt_write,
    input  logic              flt_exec,
    input  logic              flt_alt,
    input  logic              flt_super,
    input  logic [AW-1:0]     flt_addr,
    input  logic              ctl_enable,
    input  logic              ctl_nofault,
    input  logic              sw_clr,
    input  logic              sw_wr,
    input  logic [STAT_W-1:0] sw_wdata,
    output logic [STAT_W-1:0] stat_q,
    output logic [AW-1:0]     addr_q,
    output logic              trap_req,
    output logic              trap_kind,
    output logic              flush_req
);
    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [AW-1:0]     addr;
        logic              trap;
        trap_kind_e        kind;
        logic              flush;
    } state_t;

    state_t            st_d, st_q;
    logic [STAT_W-1:0] upd_stat;
    logic [AW-1:0]     upd_addr;
    logic              tc_trap, tc_flush;
    trap_kind_e        tc_kind;

    mfr_status_next #(.AW(AW)) u_next (
        .held_stat (st_q.stat),
        .held_addr (st_q.addr),
        .ev_write  (flt_write),
        .ev_exec   (flt_exec),
        .ev_alt    (flt_alt),
        .ev_super  (flt_super),
        .ev_addr   (flt_addr),
        .new_stat  (upd_stat),
        .new_addr  (upd_addr)
    );

    mfr_trap_ctl u_trap (
        .fire    (flt_valid),
        .ev_exec (flt_exec),
        .en      (ctl_enable),
        .nofault (ctl_nofault),
        .trap    (tc_trap),
        .kind    (tc_kind),
        .flush   (tc_flush)
    );

    always_comb begin
        st_d       = st_q;
        st_d.trap  = 1'b0;
        st_d.flush = 1'b0;
        if (flt_valid) begin
            st_d.stat  = upd_stat;
            st_d.addr  = upd_addr;
            st_d.trap  = tc_trap;
            st_d.kind  = tc_kind;
            st_d.flush = tc_flush;
        end else if (sw_wr) begin
            st_d.stat = sw_wdata & STAT_WMASK;
        end else if (sw_clr) begin
            st_d.stat = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{stat: '0, addr: '0, trap: 1'b0, kind: TRAP_DATA, flush: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q    = st_q.stat;
    assign addr_q    = st_q.addr;
    assign trap_req  = st_q.trap;
    assign trap_kind = st_q.kind;
    assign flush_req = st_q.flush;
endmodule

// File: rtl/mfr_checker.sv
module mfr_checker #(
    parameter int AW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flt_valid,
    input logic          flt_exec,
    input logic          ctl_enable,
    input logic          ctl_nofault,
    input logic          sw_clr,
    input logic          sw_wr,
    input logic [31:0]   stat_q,
    input logic [AW-1:0] addr_q,
    input logic          trap_req,
    input logic          trap_kind,
    input logic          flush_req
);
    logic [2:0] held;
    assign held = stat_q[4:2];

    // R2
    assert_rebuild_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && (held == 3'd0 || held > 3'd4)) |=> (stat_q[4:2] == 3'd5 && stat_q[1]));

    // R3 and R4
    assert_keep_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && held != 3'd0 && held <= 3'd4) |=> (stat_q == ($past(stat_q) | 32'd1)));

    assert_fetch_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_exec) |=> $stable(addr_q));

    assert_trap_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_req) |-> $past(flt_valid && ctl_enable && !ctl_nofault));

    assert_trap_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_kind == $past(flt_exec)));

    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && ctl_nofault) |=> (flush_req && !trap_req));

    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_req, flush_req}));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !sw_wr && !flt_valid) |=> (stat_q == 32'd0));
endmodule

bind mmu_fault_recorder mfr_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flt_valid   (flt_valid),
    .flt_exec    (flt_exec),
    .ctl_enable  (ctl_enable),
    .ctl_nofault (ctl_nofault),
    .sw_clr      (sw_clr),
    .sw_wr       (sw_wr),
    .stat_q      (stat_q),
    .addr_q      (addr_q),
    .trap_req    (trap_req),
    .trap_kind   (trap_kind),
    .flush_req   (flush_req)
);

// File: tb/mmu_fault_recorder_test.sv
`timescale 1ns/1ps
module mmu_fault_recorder_test;
    localparam int AW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flt_valid = 0, flt_write = 0, flt_exec = 0, flt_alt = 0, flt_super = 0;
    logic [AW-1:0] flt_addr = '0;
    logic          ctl_enable = 0, ctl_nofault = 0, sw_clr = 0, sw_wr = 0;
    logic [31:0]   sw_wdata = '0;
    logic [31:0]   stat_q;
    logic [AW-1:0] addr_q;
    logic          trap_req, trap_kind, flush_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mmu_fault_recorder #(.AW(AW)) uut (.*);

    function automatic logic [31:0] rebuilt(input logic w, x, a, s);
        return (32'(a) << 16) | (32'(w) << 7) | (32'(x) << 6) | (32'(s) << 5) | 32'h16;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic fault(input logic w, x, a, s, input logic [AW-1:0] ad);
        flt_valid = 1; flt_write = w; flt_exec = x; flt_alt = a; flt_super = s; flt_addr = ad;
        tick();
        flt_valid = 0; flt_write = 0; flt_exec = 0; flt_alt = 0; flt_super = 0;
    endtask

    task automatic swwrite(input logic [31:0] v);
        sw_wr = 1; sw_wdata = v; tick(); sw_wr = 0;
    endtask

    task automatic swclear;
        sw_clr = 1; tick(); sw_clr = 0;
    endtask

    task automatic t_reset;
        chk("R1 stat", stat_q, 0);
        chk("R1 addr", addr_q, 0);
        chk("R1 trap", trap_req, 0);
        chk("R1 flush", flush_req, 0);
    endtask

    task automatic t_data_fault;
        ctl_enable = 1; ctl_nofault = 0;
        fault(1, 0, 0, 1, 36'h1_2345_6780);
        chk("R2 stat", stat_q, rebuilt(1, 0, 0, 1));
        chk("R5 addr", addr_q, 36'h1_2345_6780);
        chk("R6 trap", trap_req, 1);
        chk("R6 kind data", trap_kind, 0);
        chk("R7 no flush", flush_req, 0);
        tick();
        chk("R6 pulse", trap_req, 0);
        fault(0, 0, 0, 0, 36'h0_0000_0abc);
        chk("R4 repeat class 5", stat_q, rebuilt(0, 0, 0, 0) | 32'd1);
        chk("R5 addr repeat", addr_q, 36'h0_0000_0abc);
    endtask

    task automatic t_clear_read;
        sw_clr = 1;
        #0.5;
        chk("R9 visible", stat_q, rebuilt(0, 0, 0, 0) | 32'd1);
        tick(); sw_clr = 0;
        chk("R9 zeroed", stat_q, 0);
    endtask

    task automatic t_fetch_fault;
        fault(0, 1, 1, 0, 36'h7_7777_7770);
        chk("R2 fetch stat", stat_q, rebuilt(0, 1, 1, 0));
        chk("R5 fetch addr kept", addr_q, 36'h0_0000_0abc);
        chk("R6 kind code", trap_kind, 1);
        chk("R6 trap fetch", trap_req, 1);
    endtask

    task automatic t_mask_and_high;
        swclear();
        swwrite(32'hFFFF_FFFF);
        chk("R8 mask", stat_q, 32'h0003_FFFF);
        fault(1, 0, 0, 0, 36'h0_0000_1000);
        chk("R2 class7 replaced", stat_q, rebuilt(1, 0, 0, 0));
        chk("R5 class7 addr", addr_q, 36'h0_0000_1000);
        swwrite(32'h0000_0018);
        fault(0, 0, 1, 1, 36'h0_0000_2000);
        chk("R2 class6 no ovf", stat_q, rebuilt(0, 0, 1, 1));
    endtask

    task automatic t_keep_low;
        swwrite(32'h0000_0088);
        fault(0, 0, 1, 1, 36'h0_0000_3000);
        chk("R3 class2 kept", stat_q, 32'h0000_0089);
        chk("R5 addr held", addr_q, 36'h0_0000_2000);
        swwrite(32'h0000_0010);
        fault(1, 1, 0, 0, 36'h0_0000_4000);
        chk("R4 class4 ovf", stat_q, 32'h0000_0011);
    endtask

    task automatic t_controls;
        swclear();
        ctl_enable = 1; ctl_nofault = 1;
        fault(0, 0, 0, 0, 36'h0_0000_5000);
        chk("R7 flush", flush_req, 1);
        chk("R7 no trap", trap_req, 0);
        tick();
        chk("R7 pulse", flush_req, 0);
        ctl_enable = 0; ctl_nofault = 0;
        fault(0, 0, 0, 0, 36'h0_0000_6000);
        chk("R6 disabled no trap", trap_req, 0);
        chk("R7 disabled no flush", flush_req, 0);
    endtask

    task automatic t_collide;
        swclear();
        sw_clr = 1;
        fault(1, 0, 0, 0, 36'h0_0000_7000);
        sw_clr = 0;
        chk("R10 fault over clear", stat_q, rebuilt(1, 0, 0, 0));
        swclear();
        sw_wr = 1; sw_wdata = 32'h0000_0008;
        fault(0, 0, 0, 1, 36'h0_0000_8000);
        sw_wr = 0;
        chk("R10 fault over write", stat_q, rebuilt(0, 0, 0, 1));
        sw_clr = 1; sw_wr = 1; sw_wdata = 32'h0000_00C0;
        tick();
        sw_clr = 0; sw_wr = 0;
        chk("R10 write over clear", stat_q, 32'h0000_00C0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_data_fault();
        t_clear_read();
        t_fetch_fault();
        t_mask_and_high();
        t_keep_low();
        t_controls();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule